// File: doc/BRIEF.md
# Priority Transfer Switch Controller

This block chooses which of four supplies feeds the load and drives one contactor enable for the chosen supply. Three supplies are utility phases and the fourth is a backup generator. Each supply reports a single logic-level "present" sense bit. The controller first resynchronises and debounces each sense bit. It then picks the preferred available supply and moves the load between supplies break-before-make, with a dead interval set by a parameter.

The utility phases always win over the generator. Among the phases the fixed preference is phase 0, then phase 1, then phase 2. Once the load sits on a phase, it stays there while that phase remains present. When the load is on the generator and a phase comes back, the controller returns to utility only after that phase has stayed present for a parameterised qualification time. When no supply is present, every contactor stays open. Analog conditioning, relay drivers and generator start logic are outside this block.

Top module: `xfer_switch_ctrl`

## Requirements
- R1: When the controller connects from the open state or at the end of a dead interval, it picks the lowest-numbered qualified utility phase. Sense and enable bit 0 is phase 0, bit 1 is phase 1, bit 2 is phase 2.
- R2: At most one bit of `contactor_en` is high in any cycle.
- R3: The generator enable (bit 3) rises only when no utility phase is qualified.
- R4: A change of enable passes through an all-low interval of at least `DEAD_CYCLES` cycles. One enable never switches directly to another.
- R5: With no supply qualified, all enables are low from the next cycle on.
- R6: A sense level that holds for fewer than `DEB_CYCLES` cycles after the two-flop synchronizer has no effect on the qualified state or on the outputs.
- R7: A synchronous active-high `rst` drives all enables low in the next cycle. No supply is connected until `DEB_CYCLES`+3 cycles after reset is released.
- R8: While a connected utility phase stays qualified, the controller keeps it, even when a preferred phase returns.
- R9: With the generator connected, a transfer back to utility starts only after a phase has been qualified for `RET_CYCLES` consecutive cycles.
- R10: The new supply is chosen when the dead interval ends, and checked again in the cycle it is enabled. If the intended target drops out during the dead interval, no enable for it is ever asserted.
- R11: When the connected phase is removed, the new enable appears exactly `DEB_CYCLES`+`DEAD_CYCLES`+4 clock edges after the sense change, and outputs are low for the final `DEAD_CYCLES`+1 of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sense | input | 4 | Raw present bits: [0..2] utility phases, [3] generator |
| contactor_en | output | 4 | Registered contactor enables, same bit order as `src_sense` |

## Verification
A corrupted state register or dead-time counter shows at the ports as two enables high at once, or as an enable that appears within `DEAD_CYCLES` cycles of the previous one dropping. Both are visible within a single transfer. A wrong debounce or return-qualification count shifts the edge at which an enable rises. The bench therefore samples the exact cycle on either side of that edge. A wrong priority decision shows as the wrong enable bit after the outputs settle, and the vector table shows it for every source pattern.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int N_UTIL  = 3;
  localparam int N_SRC   = N_UTIL + 1;
  localparam int GEN_IDX = N_UTIL;
  localparam int IDX_W   = $clog2(N_SRC);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONNECTED,
    ST_BREAK,
    ST_MAKE
  } xfer_state_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Lowest-numbered qualified utility phase wins; generator only as last resort.
  function automatic pick_t pick_source(input logic [N_SRC-1:0] q);
    pick_t p;
    p.valid = 1'b0;
    p.idx   = '0;
    for (int i = N_UTIL - 1; i >= 0; i--) begin
      if (q[i]) begin
        p.valid = 1'b1;
        p.idx   = IDX_W'(i);
      end
    end
    if (!p.valid && q[GEN_IDX]) begin
      p.valid = 1'b1;
      p.idx   = IDX_W'(GEN_IDX);
    end
    return p;
  endfunction
endpackage

// File: rtl/xfer_sense_filter.sv
module xfer_sense_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_raw,
  output logic present
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          sync1, sync2;
  logic [CW-1:0] stable_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      present    <= 1'b0;
      stable_cnt <= '0;
    end else begin
      sync1 <= sense_raw;
      sync2 <= sync1;
      if (sync2 == present) begin
        stable_cnt <= '0;
      end else if (stable_cnt == CW'(DEB_CYCLES - 1)) begin
        present    <= sync2;
        stable_cnt <= '0;
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_return_timer.sv
module xfer_return_timer #(
  parameter int RET_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic present,
  output logic ready
);
  localparam int CW = $clog2(RET_CYCLES + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !present) begin
      run_cnt <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      if (run_cnt == CW'(RET_CYCLES - 1)) begin
        ready <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import xfer_pkg::*;
#(
  parameter int DEAD_CYCLES   = 32,
  parameter int SETTLE_CYCLES = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  qual,
  input  logic [N_UTIL-1:0] util_ready,
  output logic [N_SRC-1:0]  contactor_en
);
  localparam int DW = $clog2(DEAD_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  xfer_state_t      state;
  logic [IDX_W-1:0] cur_idx, tgt_idx;
  logic [DW-1:0]    dead_cnt;
  logic [SW-1:0]    settle_cnt;
  logic             settled;
  pick_t            best;
  logic             leave_gen;

  always_comb begin
    best      = pick_source(qual);
    leave_gen = (cur_idx == IDX_W'(GEN_IDX)) && (|util_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      contactor_en <= '0;
      cur_idx      <= '0;
      tgt_idx      <= '0;
      dead_cnt     <= '0;
      settle_cnt   <= '0;
      settled      <= 1'b0;
    end else begin
      if (!settled) begin
        if (settle_cnt == SW'(SETTLE_CYCLES - 1)) settled <= 1'b1;
        else                                      settle_cnt <= settle_cnt + 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (settled && best.valid) begin
            tgt_idx <= best.idx;
            state   <= ST_MAKE;
          end
        end
        ST_MAKE: begin
          if (best.valid && best.idx == tgt_idx) begin
            contactor_en <= N_SRC'(1) << tgt_idx;
            cur_idx      <= tgt_idx;
            state        <= ST_CONNECTED;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_CONNECTED: begin
          if (!qual[cur_idx] || leave_gen) begin
            contactor_en <= '0;
            dead_cnt     <= '0;
            state        <= ST_BREAK;
          end
        end
        ST_BREAK: begin
          if (dead_cnt == DW'(DEAD_CYCLES - 1)) begin
            if (best.valid) begin
              tgt_idx <= best.idx;
              state   <= ST_MAKE;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            dead_cnt <= dead_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_switch_ctrl.sv
module xfer_switch_ctrl
  import xfer_pkg::*;
#(
  parameter int DEB_CYCLES  = 16,
  parameter int DEAD_CYCLES = 32,
  parameter int RET_CYCLES  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_sense,
  output logic [N_SRC-1:0] contactor_en
);
  localparam int SETTLE_CYCLES = DEB_CYCLES + 3;

  logic [N_SRC-1:0]  src_qual;
  logic [N_UTIL-1:0] util_ready;

  for (genvar i = 0; i < N_SRC; i++) begin : g_filter
    xfer_sense_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
      .clk       (clk),
      .rst       (rst),
      .sense_raw (src_sense[i]),
      .present   (src_qual[i])
    );
  end

  for (genvar i = 0; i < N_UTIL; i++) begin : g_return
    xfer_return_timer #(.RET_CYCLES(RET_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .present (src_qual[i]),
      .ready   (util_ready[i])
    );
  end

  xfer_fsm #(
    .DEAD_CYCLES   (DEAD_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .qual         (src_qual),
    .util_ready   (util_ready),
    .contactor_en (contactor_en)
  );
endmodule

// File: rtl/xfer_switch_ctrl_chk.sv
module xfer_switch_ctrl_chk
  import xfer_pkg::*;
#(
  parameter int DEAD_CYCLES = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_qual,
  input logic [N_SRC-1:0] contactor_en
);
  localparam int LW = $clog2(DEAD_CYCLES + 2);

  logic [LW-1:0] low_run;
  logic          had_conn;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      had_conn <= 1'b0;
    end else if (contactor_en == '0) begin
      if (low_run != LW'(DEAD_CYCLES + 1)) low_run <= low_run + 1'b1;
    end else begin
      low_run  <= '0;
      had_conn <= 1'b1;
    end
  end

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(contactor_en)); // R2

  AST_GEN_LAST_RESORT: assert property (@(posedge clk) disable iff (rst)
    $rose(contactor_en[GEN_IDX]) |-> $past(src_qual[N_UTIL-1:0] == '0)); // R3

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
    (contactor_en != '0) |=> (contactor_en == '0 || $stable(contactor_en))); // R4

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (contactor_en != '0 && $past(contactor_en) == '0 && had_conn)
      |-> (low_run >= LW'(DEAD_CYCLES))); // R4

  AST_NONE_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (src_qual == '0) |=> (contactor_en == '0)); // R5

  AST_RESET_OPEN: assert property (@(posedge clk)
    rst |=> (contactor_en == '0)); // R7
endmodule

bind xfer_switch_ctrl xfer_switch_ctrl_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_qual     (src_qual),
  .contactor_en (contactor_en)
);

// File: tb/test_xfer_switch_ctrl.sv
module test_xfer_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int DEAD = 6;
  localparam int RET  = 10;
  localparam int SETTLE_WAIT = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_sense = 4'b0000;
  logic [3:0] contactor_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor state
  int   low_run = 0;
  bit   had_conn = 1'b0;
  logic [3:0] prev_en = 4'b0000;
  int   disturb = 0;
  bit   y_seen = 1'b0;
  int   gaps = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_switch_ctrl #(
    .DEB_CYCLES (DEB),
    .DEAD_CYCLES(DEAD),
    .RET_CYCLES (RET)
  ) i_xfer_switch_ctrl (
    .clk          (clk),
    .rst          (rst),
    .src_sense    (src_sense),
    .contactor_en (contactor_en)
  );

  // Stimulus vectors: upper nibble = sense {gen,B,Y,R}, lower nibble = expected enables
  localparam logic [7:0] VECS [0:9] = '{
    8'h71,  // R1: all phases present -> phase 0
    8'h62,  // R1: phase 0 lost -> phase 1
    8'h72,  // R8: phase 0 returns, stay on phase 1
    8'h44,  // R1: only phase 2 left
    8'h88,  // R3: only generator
    8'hC4,  // R9: phase 2 returns, back to utility after qualification
    8'h00,  // R5: nothing present
    8'h88,  // R3: generator alone again
    8'hB1,  // R9 R1: phases 0 and 1 return, phase 0 preferred
    8'h00   // R5: all gone
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_en(input logic [3:0] exp, input string tag);
    checks++;
    if (contactor_en !== exp) begin
      errors++;
      $display("FAIL %s: contactor_en=%b expected %b", tag, contactor_en, exp);
    end
  endtask

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: value=%0d expected %0d", tag, act, exp);
    end
  endtask

  // Port monitor for one-hot and break-before-make
  always @(negedge clk) begin
    if (rst) begin
      low_run  = 0;
      had_conn = 1'b0;
    end else begin
      if ($countones(contactor_en) > 1) begin
        errors++;
        $display("FAIL R2: contactor_en=%b expected at most one bit", contactor_en);
      end
      if (prev_en != 4'b0000 && contactor_en != 4'b0000 && prev_en != contactor_en) begin
        errors++;
        $display("FAIL R4: direct swap %b -> %b expected all-low gap", prev_en, contactor_en);
      end
      if (prev_en == 4'b0000 && contactor_en != 4'b0000 && had_conn) begin
        checks++;
        gaps++;
        if (low_run < DEAD) begin
          errors++;
          $display("FAIL R4: gap=%0d expected >= %0d", low_run, DEAD);
        end
      end
      if (contactor_en == 4'b0000) low_run++;
      else begin
        low_run  = 0;
        had_conn = 1'b1;
      end
      if (contactor_en != 4'b0001) disturb++;
      if (contactor_en[1]) y_seen = 1'b1;
    end
    prev_en = contactor_en;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    tick(3);
    check_en(4'b0000, "R7 during reset");
    src_sense = 4'b0111;
    rst = 1'b0;
    tick(DEB);
    check_en(4'b0000, "R7 before settle");

    // Vector table
    for (int v = 0; v < 10; v++) begin
      src_sense = VECS[v][7:4];
      tick(40);
      checks++;
      if (contactor_en !== VECS[v][3:0]) begin
        errors++;
        $display("FAIL vector %0d (R1/R3/R5/R8/R9): contactor_en=%b expected %b",
                 v, contactor_en, VECS[v][3:0]);
      end
    end

    // R11: exact transfer latency phase 0 -> phase 1
    src_sense = 4'b0011;
    tick(SETTLE_WAIT);
    check_en(4'b0001, "R11 setup");
    src_sense = 4'b0010;
    tick(3 + DEB + DEAD);
    check_en(4'b0000, "R11 still in dead interval");
    tick(1);
    check_en(4'b0010, "R11 new enable edge");

    // R9: return from generator timing
    src_sense = 4'b1000;
    tick(SETTLE_WAIT);
    check_en(4'b1000, "R9 setup on generator");
    src_sense = 4'b1001;
    tick(DEB + RET + 1);
    check_en(4'b1000, "R9 generator held during return qualification");
    tick(DEAD + 6);
    check_en(4'b0001, "R9 returned to phase 0");

    // R6: short glitch ignored
    src_sense = 4'b0001;
    tick(20);
    disturb = 0;
    src_sense = 4'b0000;
    tick(2);
    src_sense = 4'b0001;
    tick(30);
    check_val(disturb, 0, "R6 glitch disturbed output cycles");
    check_en(4'b0001, "R6 still on phase 0");

    // R10: target drops out during dead interval
    src_sense = 4'b0111;
    tick(30);
    check_en(4'b0001, "R10 setup");
    y_seen = 1'b0;
    src_sense = 4'b0110;
    tick(2);
    src_sense = 4'b0100;
    tick(SETTLE_WAIT);
    check_en(4'b0100, "R10 landed on phase 2");
    check_val(int'(y_seen), 0, "R10 phase 1 enable seen");

    // R7: reset mid-connection
    rst = 1'b1;
    tick(1);
    check_en(4'b0000, "R7 reset opens contactors");
    rst = 1'b0;
    tick(DEB + 2);
    check_en(4'b0000, "R7 no connect before settle");
    tick(SETTLE_WAIT);
    check_en(4'b0100, "R7 reconnect after settle");

    // R4/R2: monitor saw transfers
    checks++;
    if (gaps < 5) begin
      errors++;
      $display("FAIL R4: observed gaps=%0d expected >= 5", gaps);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule